// File: doc/BRIEF.md
# Triggered RF Path Switch Control

This block is the register core of a four-throw RF aperture switch. A serial bus slave hands it single register writes (strobe, address, data). It holds two registers: a control register with the power mode, three trigger masks and three trigger strobes, and a switch register that selects which of four RF ports connect to the common port, or whether the common port is shorted to ground. The switch register is staged. A write lands in a shadow copy and reaches the active copy only when its trigger fires, unless that trigger is masked, in which case the write takes effect directly.

The active switch value is decoded into four port enables and a ground-short enable. Outside normal power mode every output is forced off. The stored values stay as they are, so a return to normal mode restores the previous path without a rewrite. A write of a one to the software reset bit of the status address returns all state to its defaults. The block has a combinational read port so the bus slave can return register contents.

Top module: `trig_path_ctrl`

## Requirements
- R1: After reset the port enables and ground short are 0, the switch register reads 0x00 and the control register reads 0x80: power mode 2'b10 (low power) in bits 7:6, all three masks (bits 5:3) clear.
- R2: When the mask of the switch register's trigger is set (control bit 3+TRIG_IDX, default bit 3), a write to the switch register (address 0x00) takes effect on the outputs after the write's clock edge.
- R3: When that mask is clear, a switch register write changes only the shadow copy; port enables and ground short keep their values.
- R4: A control register (address 0x1C) write with bit TRIG_IDX set copies the shadow into the active switch value in that edge; a write setting only another trigger bit leaves the active value unchanged.
- R5: Control register bits 2:0 are strobes and always read back as 0; bits 7:3 read back as last written.
- R6: In normal mode (power mode 2'b00) with switch bit 6 clear, port_en[i] equals switch bit i for i = 0..3; a value of 0x00 opens all ports.
- R7: Switch bit 6 set drives gnd_short to 1 and all port enables to 0, whatever bits 3:0 hold.
- R8: With power mode 2'b01, 2'b10 or 2'b11 all outputs are 0; the stored switch value is kept and reappears when the mode goes back to 2'b00.
- R9: A write to address 0x1A with bit 7 set resets active, shadow and control state to their R1 defaults.
- R10: A read of address 0x00 returns the active switch value, not the shadow; other unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Combinational read data |
| port_en | output | 4 | RF port enables, bit i for port i+1 |
| gnd_short | output | 1 | Common port short-to-ground enable |

## Verification
The assertions watch on every cycle that outputs are off outside normal mode, that the ground short never coexists with a port enable, that unmasked writes leave the outputs alone, that a trigger loads exactly the previous shadow and that a mode change leaves the active value intact. Whether the shadow content survives a masked/unmasked sequence, whether a software reset clears the shadow so that a later trigger loads zero, and whether a restored mode brings back the old path are shown only by the bench's scenarios and its cycle-by-cycle reference model.

// File: rtl/trig_path_ctrl.sv
module trig_path_ctrl #(
  parameter int          ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] SW_ADDR   = 5'h00,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h1C,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h1A,
  parameter int          TRIG_IDX  = 0,
  parameter logic [7:0]  CTRL_RST  = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [3:0]        port_en,
  output logic              gnd_short
);

  localparam int MASK_BIT = 3 + TRIG_IDX;

  logic [7:0] act_q, shd_q;
  logic [1:0] pm_q;
  logic [2:0] msk_q;

  wire wr_sw   = wr_en && (wr_addr == SW_ADDR);
  wire wr_ctl  = wr_en && (wr_addr == CTRL_ADDR);
  wire wr_rst  = wr_en && (wr_addr == STAT_ADDR) && wr_data[7];
  wire masked  = msk_q[TRIG_IDX];
  wire fire    = wr_ctl && wr_data[TRIG_IDX];
  wire run     = (pm_q == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      shd_q <= '0;
      pm_q  <= CTRL_RST[7:6];
      msk_q <= CTRL_RST[5:3];
    end else if (wr_rst) begin
      act_q <= '0;
      shd_q <= '0;
      pm_q  <= CTRL_RST[7:6];
      msk_q <= CTRL_RST[5:3];
    end else begin
      if (wr_sw) shd_q <= wr_data;
      if (wr_sw && masked) act_q <= wr_data;
      else if (fire)       act_q <= shd_q;
      if (wr_ctl) begin
        pm_q  <= wr_data[7:6];
        msk_q <= wr_data[5:3];
      end
    end
  end

  assign gnd_short = run && act_q[6];
  assign port_en   = (run && !act_q[6]) ? act_q[3:0] : 4'b0000;

  always_comb begin
    if (rd_addr == SW_ADDR)        rd_data = act_q;
    else if (rd_addr == CTRL_ADDR) rd_data = {pm_q, msk_q, 3'b000};
    else                           rd_data = 8'h00;
  end

  a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw && masked |=> act_q == $past(wr_data));

  a_r3_shadow_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw && !masked |=> $stable(port_en) && $stable(gnd_short));

  a_r4_trigger_load: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> act_q == $past(shd_q));

  a_r5_strobe_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == CTRL_ADDR |-> rd_data[2:0] == 3'b000);

  a_r7_short_excl: assert property (@(posedge clk) disable iff (!rst_n)
    gnd_short |-> port_en == 4'b0000);

  a_r8_safe_off: assert property (@(posedge clk) disable iff (!rst_n)
    pm_q != 2'b00 |-> port_en == 4'b0000 && !gnd_short);

  a_r8_keep_value: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && !wr_data[TRIG_IDX] |=> $stable(act_q));

  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> act_q == 8'h00 && shd_q == 8'h00 && pm_q == CTRL_RST[7:6] && msk_q == CTRL_RST[5:3]);

  initial assert (MASK_BIT <= 5) else $error("TRIG_IDX out of range");

endmodule

// File: tb/sim_trig_path_ctrl.sv
module sim_trig_path_ctrl;
  localparam int PERIOD = 10;

  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [3:0] port_en;
  logic       gnd_short;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  trig_path_ctrl u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
                     .rd_data, .port_en, .gnd_short);

  always #(PERIOD/2) clk = ~clk;

  // reference model state
  int m_act, m_shd, m_pm, m_msk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_shd = 0; m_pm = 2; m_msk = 0;
    end else if (wr_en) begin
      if (wr_addr == 5'h00) begin
        m_shd = wr_data;
        if (m_msk % 2 == 1) m_act = wr_data;
      end else if (wr_addr == 5'h1C) begin
        m_pm  = wr_data[7:6];
        m_msk = wr_data[5:3];
        if (wr_data[0]) m_act = m_shd;
      end else if (wr_addr == 5'h1A && wr_data[7]) begin
        m_act = 0; m_shd = 0; m_pm = 2; m_msk = 0;
      end
    end
  end

  function automatic int exp_ports();
    if (m_pm != 0 || ((m_act / 64) % 2) == 1) return 0;
    return m_act % 16;
  endfunction

  function automatic int exp_gnd();
    return (m_pm == 0 && ((m_act / 64) % 2) == 1) ? 1 : 0;
  endfunction

  function automatic int exp_rd(int a);
    if (a == 0)  return m_act;
    if (a == 28) return m_pm * 64 + m_msk * 8;
    return 0;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    n_chk++;
    if (int'(port_en) != exp_ports() || int'(gnd_short) != exp_gnd() ||
        int'(rd_data) != exp_rd(int'(rd_addr))) begin
      n_fail++;
      $display("FAIL R6 R7 R8 model compare: ports=%h gnd=%0d rd=%h exp ports=%h gnd=%0d rd=%h",
               port_en, gnd_short, rd_data, exp_ports(), exp_gnd(), exp_rd(int'(rd_addr)));
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(string tag, logic [4:0] a, int exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 ports", port_en, 0);
    chk("R1 gnd", gnd_short, 0);
    rd_chk("R1 ctrl", 5'h1C, 8'h80);
    rd_chk("R1 sw", 5'h00, 8'h00);
    // R3 / R10
    wr(5'h1C, 8'h00);
    wr(5'h00, 8'h05);
    chk("R3 shadow only", port_en, 0);
    rd_chk("R10 active read", 5'h00, 8'h00);
    // R4 / R6 / R5
    wr(5'h1C, 8'h01);
    chk("R4 trigger load", port_en, 4'b0101);
    rd_chk("R5 strobe reads zero", 5'h1C, 8'h00);
    wr(5'h00, 8'h0A);
    wr(5'h1C, 8'h06);
    chk("R4 other trigger ignored", port_en, 4'b0101);
    // R2
    wr(5'h1C, 8'h08);
    wr(5'h00, 8'h0F);
    chk("R2 masked direct", port_en, 4'b1111);
    rd_chk("R5 mask readback", 5'h1C, 8'h08);
    wr(5'h00, 8'h00);
    chk("R6 isolation", port_en, 0);
    // R7
    wr(5'h00, 8'h4F);
    chk("R7 gnd", gnd_short, 1);
    chk("R7 ports off", port_en, 0);
    // R8
    wr(5'h00, 8'h03);
    wr(5'h1C, 8'h88);
    chk("R8 low power off", port_en, 0);
    rd_chk("R8 value kept", 5'h00, 8'h03);
    wr(5'h1C, 8'h48);
    chk("R8 startup off", port_en, 0);
    wr(5'h1C, 8'hC8);
    chk("R8 reserved off", port_en, 0);
    wr(5'h1C, 8'h08);
    chk("R8 restored", port_en, 4'b0011);
    // R9
    wr(5'h1C, 8'h00);
    wr(5'h00, 8'h0C);
    wr(5'h1A, 8'h80);
    rd_chk("R9 ctrl default", 5'h1C, 8'h80);
    wr(5'h1C, 8'h01);
    chk("R9 shadow cleared", port_en, 0);
    rd_chk("R10 unused addr", 5'h05, 8'h00);
    // randomized traffic checked by the model each cycle
    for (int i = 0; i < 400; i++) begin
      logic [4:0] a;
      logic [7:0] d;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      d = lf[15:8];
      case (lf[2:0])
        3'd0, 3'd1, 3'd2: a = 5'h00;
        3'd3, 3'd4:       a = 5'h1C;
        3'd5: begin a = 5'h1A; d[7] = (lf[15:12] == 4'h0); end
        default:          a = lf[8:4];
      endcase
      rd_addr = lf[3] ? 5'h00 : (lf[4] ? 5'h1C : lf[9:5]);
      if (lf[11]) wr(a, d); else @(negedge clk);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule